// File: doc/BRIEF.md
# Sign-Magnitude Motor PWM Generator

This block drives the low side of several DC motor H-bridges from signed speed commands. Every channel shares one free-running up-counter that wraps after its all-ones value, so with the default 10-bit width one PWM period lasts 1024 clocks. Each channel turns its two's-complement command into a duty magnitude and a direction bit. The direction bit can be inverted per channel through a reverse mask, which makes up for motors that are wired backwards.

The control loop presents new commands for all channels on a flat bus and pulses a single update strobe. The commands and the reverse mask are captured together in that cycle. Each channel then swaps its duty and its direction together at the next period boundary. A channel therefore never runs a mixed period, and no channel lags another by a period.

Top module: `sm_pwm_gen`

## Requirements
- R1: The shared counter resets to 0, increments by one each clock and wraps from 1023 to 0, so a PWM period is 1024 clocks.
- R2: The PWM output of a channel is high while the counter is below the channel's active compare value and low otherwise. A compare value of 1023 is low only at count 1023.
- R3: A positive command gives a compare value equal to the command, with the direction high before the reverse step.
- R4: A negative command gives a compare value equal to its negation, with the direction low before the reverse step. The command -1024 saturates to a compare value of 1023.
- R5: A zero command gives a compare value of 0, so the output stays low all period, and the direction is low before the reverse step.
- R6: Bit i of reverseMask is XORed onto the decoded direction of channel i, and it is sampled at the update strobe.
- R7: Captured values become active at the first clock where the counter reads 0 after capture. Until then the duty and direction of the previous period stay unchanged, and duty and direction switch in the same cycle.
- R8: An update strobe captures the commands of all channels in the same cycle. Commands that change without a strobe have no effect on the outputs.
- R9: A strobe in the cycle where the counter reads 1023 takes effect in the period that starts on the very next clock.
- R10: A synchronous active-high reset clears the counter and all buffers, which drives every PWM and direction output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| updStrobe | input | 1 | Capture the commands and the reverse mask of all channels |
| cmdFlat | input | NUM_CH*CMD_W | Command of channel i in bits [i*CMD_W +: CMD_W], two's complement |
| reverseMask | input | NUM_CH | Bit i inverts the direction of channel i |
| pwmOut | output | NUM_CH | PWM output of each channel |
| dirOut | output | NUM_CH | Direction output of each channel |

## Verification
A wrong counter phase or a stale active buffer shows up on every channel's PWM edge positions within one period. This is why the bench predicts the expected level of each output on every clock, and does not only count duty at the end. A fault in the pending buffer, or a mistimed swap, appears as a direction or duty change away from count 0, up to 1024 clocks after the strobe. The captures at the last count and the saturation of -1024 are the cases where an off-by-one shows up immediately.

// File: rtl/sm_pwm_pkg.sv
package sm_pwm_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic wrap;     // counter is at its last count
    logic capture;  // latch new commands this cycle
  } pwmCtrl_t;
endpackage

// File: rtl/sm_pwm_ctrl.sv
module sm_pwm_ctrl
  import sm_pwm_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             updStrobe,
  output logic [CNT_W-1:0] cnt,
  output pwmCtrl_t         ctrl
);
  localparam logic [CNT_W-1:0] TOP_VAL = '1;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (cnt == TOP_VAL) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  always_comb begin
    ctrl.wrap    = (cnt == TOP_VAL);
    ctrl.capture = updStrobe;
  end
endmodule

// File: rtl/sm_pwm_datapath.sv
module sm_pwm_datapath
  import sm_pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 10,
  parameter int CMD_W  = CNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  pwmCtrl_t                ctrl,
  input  logic [CNT_W-1:0]        cnt,
  input  logic [NUM_CH*CMD_W-1:0] cmdFlat,
  input  logic [NUM_CH-1:0]       reverseMask,
  output logic [NUM_CH-1:0]       pwmOut,
  output logic [NUM_CH-1:0]       dirOut
);
  localparam int OVF_W = CMD_W - CNT_W;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [CMD_W-1:0] cmdCh;
    logic [CMD_W-1:0] absVal;
    logic [CNT_W-1:0] newMag;
    logic             newDir;
    logic [CNT_W-1:0] pendMag, actMag;
    logic             pendDir, actDir;

    always_comb begin
      cmdCh  = cmdFlat[i*CMD_W +: CMD_W];
      absVal = cmdCh[CMD_W-1] ? (~cmdCh + 1'b1) : cmdCh;
      if (absVal[CMD_W-1 -: OVF_W] != '0) newMag = '1;
      else                                newMag = absVal[CNT_W-1:0];
      newDir = ((cmdCh != '0) && !cmdCh[CMD_W-1]) ^ reverseMask[i];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pendMag <= '0;
        pendDir <= 1'b0;
        actMag  <= '0;
        actDir  <= 1'b0;
      end else begin
        if (ctrl.capture) begin
          pendMag <= newMag;
          pendDir <= newDir;
        end
        if (ctrl.wrap) begin
          actMag <= ctrl.capture ? newMag : pendMag;
          actDir <= ctrl.capture ? newDir : pendDir;
        end
      end
    end

    assign pwmOut[i] = (cnt < actMag);
    assign dirOut[i] = actDir;
  end
endmodule

// File: rtl/sm_pwm_gen.sv
module sm_pwm_gen
  import sm_pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 10,
  parameter int CMD_W  = CNT_W + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    updStrobe,
  input  logic [NUM_CH*CMD_W-1:0] cmdFlat,
  input  logic [NUM_CH-1:0]       reverseMask,
  output logic [NUM_CH-1:0]       pwmOut,
  output logic [NUM_CH-1:0]       dirOut
);
  logic [CNT_W-1:0] cntVal;
  pwmCtrl_t         ctrlBus;

  sm_pwm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .updStrobe(updStrobe), .cnt(cntVal), .ctrl(ctrlBus)
  );

  sm_pwm_datapath #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .CMD_W(CMD_W)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrlBus), .cnt(cntVal), .cmdFlat(cmdFlat),
    .reverseMask(reverseMask), .pwmOut(pwmOut), .dirOut(dirOut)
  );
endmodule

// File: rtl/sm_pwm_checker.sv
module sm_pwm_checker #(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [CNT_W-1:0]  cnt,
  input logic [NUM_CH-1:0] pwmOut,
  input logic [NUM_CH-1:0] dirOut
);
  localparam logic [CNT_W-1:0] TOP_VAL = '1;

  p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (cnt == TOP_VAL) |=> (cnt == '0));
  p_step_r1: assert property (@(posedge clk) disable iff (rst)
    (cnt != TOP_VAL) |=> (cnt == $past(cnt) + 1'b1));
  p_last_low_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt == TOP_VAL) |-> (pwmOut == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    p_rise_at_wrap_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(pwmOut[i]) |-> (cnt == '0));
    p_no_fall_at_wrap_r2: assert property (@(posedge clk) disable iff (rst)
      $fell(pwmOut[i]) |-> (cnt != '0));
    p_dir_at_wrap_r7: assert property (@(posedge clk) disable iff (rst)
      !$stable(dirOut[i]) |-> (cnt == '0));
  end
endmodule

bind sm_pwm_gen sm_pwm_checker #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cnt(cntVal), .pwmOut(pwmOut), .dirOut(dirOut)
);

// File: tb/test_sm_pwm_gen.sv
`timescale 1ns/1ps
module test_sm_pwm_gen;
  localparam int NCH = 2;
  localparam int CW  = 11;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           updStrobe = 1'b0;
  logic [NCH*CW-1:0] cmdFlat = '0;
  logic [NCH-1:0] reverseMask = '0;
  logic [NCH-1:0] pwmOut, dirOut;

  int nChecks = 0;
  int nFails  = 0;

  // reference model state
  int mCnt = 0;
  int mPendMag[NCH], mPendDir[NCH], mActMag[NCH], mActDir[NCH];
  bit modelLive = 0;

  always #2.5 clk = ~clk;

  sm_pwm_gen #(.NUM_CH(NCH), .CNT_W(10), .CMD_W(CW)) i_sm_pwm_gen (
    .clk(clk), .rst(rst), .updStrobe(updStrobe), .cmdFlat(cmdFlat),
    .reverseMask(reverseMask), .pwmOut(pwmOut), .dirOut(dirOut)
  );

  task automatic doCheck(string req, bit ok, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int cmdOf(int ch);
    logic [CW-1:0] v;
    v = cmdFlat[ch*CW +: CW];
    return v[CW-1] ? int'(v) - 2048 : int'(v);
  endfunction

  // behavioural model, updated each rising edge
  always @(posedge clk) begin
    int nm[NCH];
    int nd[NCH];
    bit wrapNow;
    modelLive = 1;
    if (rst) begin
      mCnt = 0;
      for (int c = 0; c < NCH; c++) begin
        mPendMag[c] = 0; mPendDir[c] = 0; mActMag[c] = 0; mActDir[c] = 0;
      end
    end else begin
      wrapNow = (mCnt == 1023);
      for (int c = 0; c < NCH; c++) begin
        int v;
        v = cmdOf(c);
        nm[c] = (v < 0) ? -v : v;
        if (nm[c] > 1023) nm[c] = 1023;
        nd[c] = ((v > 0) ? 1 : 0) ^ int'(reverseMask[c]);
        if (wrapNow) begin
          mActMag[c] = updStrobe ? nm[c] : mPendMag[c];
          mActDir[c] = updStrobe ? nd[c] : mPendDir[c];
        end
        if (updStrobe) begin
          mPendMag[c] = nm[c]; mPendDir[c] = nd[c];
        end
      end
      mCnt = wrapNow ? 0 : mCnt + 1;
    end
  end

  // per-clock comparison (R2 levels, R7 timing)
  always @(negedge clk) begin
    if (modelLive) begin
      for (int c = 0; c < NCH; c++) begin
        int ep;
        ep = (mCnt < mActMag[c]) ? 1 : 0;
        doCheck("R7 pwm level", pwmOut[c] == ep[0], int'(pwmOut[c]), ep);
        doCheck("R7 dir level", dirOut[c] == mActDir[c][0], int'(dirOut[c]), mActDir[c]);
      end
    end
  end

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finishRun();
  end

  task automatic setCmd(int c0, int c1, logic [NCH-1:0] rev);
    logic [CW-1:0] a, b;
    a = c0[CW-1:0]; b = c1[CW-1:0];
    cmdFlat = {b, a};
    reverseMask = rev;
  endtask

  task automatic strobeCmd(int c0, int c1, logic [NCH-1:0] rev);
    @(negedge clk);
    setCmd(c0, c1, rev);
    updStrobe = 1'b1;
    @(negedge clk);
    updStrobe = 1'b0;
  endtask

  task automatic waitPeriodStart();
    do @(negedge clk); while (mCnt != 0);
  endtask

  task automatic measure(int ch, output int hi);
    waitPeriodStart();
    hi = 0;
    for (int k = 0; k < 1024; k++) begin
      if (pwmOut[ch]) hi++;
      @(negedge clk);
    end
  endtask

  initial begin
    int hi, per;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    doCheck("R10 pwm after reset", pwmOut == '0, int'(pwmOut), 0);
    doCheck("R10 dir after reset", dirOut == '0, int'(dirOut), 0);
    measure(0, hi);
    doCheck("R10 duty after reset", hi == 0, hi, 0);

    strobeCmd(300, -200, 2'b00);
    doCheck("R7 dir held before boundary", dirOut == 2'b00, int'(dirOut), 0);
    measure(0, hi);
    doCheck("R3 duty ch0", hi == 300, hi, 300);
    doCheck("R3 dir ch0", dirOut[0] == 1'b1, int'(dirOut[0]), 1);
    measure(1, hi);
    doCheck("R4 duty ch1", hi == 200, hi, 200);
    doCheck("R4 dir ch1", dirOut[1] == 1'b0, int'(dirOut[1]), 0);

    // R1: rising edge to rising edge spacing
    do @(negedge clk); while (pwmOut[0]);
    do @(negedge clk); while (!pwmOut[0]);
    per = 0;
    do begin @(negedge clk); per++; end while (!(pwmOut[0] && per > 300));
    doCheck("R1 period", per == 1024, per, 1024);

    strobeCmd(0, 1023, 2'b00);
    measure(0, hi);
    doCheck("R5 zero duty", hi == 0, hi, 0);
    doCheck("R5 zero dir", dirOut[0] == 1'b0, int'(dirOut[0]), 0);
    measure(1, hi);
    doCheck("R2 full duty", hi == 1023, hi, 1023);

    strobeCmd(-1024, -1, 2'b00);
    measure(0, hi);
    doCheck("R4 saturate", hi == 1023, hi, 1023);
    measure(1, hi);
    doCheck("R4 minus one", hi == 1, hi, 1);
    doCheck("R4 neg dir", dirOut == 2'b00, int'(dirOut), 0);

    strobeCmd(500, -500, 2'b11);
    measure(0, hi);
    doCheck("R6 duty unaffected", hi == 500, hi, 500);
    doCheck("R6 reversed dirs", dirOut == 2'b10, int'(dirOut), 2);

    // R8: no strobe, new commands ignored
    @(negedge clk);
    setCmd(100, 100, 2'b00);
    measure(0, hi);
    measure(1, hi);
    doCheck("R8 duty ignored", hi == 500, hi, 500);
    doCheck("R8 dir ignored", dirOut == 2'b10, int'(dirOut), 2);

    // R9: strobe on the last count
    do @(negedge clk); while (mCnt != 1023);
    setCmd(700, -5, 2'b00);
    updStrobe = 1'b1;
    @(negedge clk);
    updStrobe = 1'b0;
    doCheck("R9 dir next period", dirOut == 2'b01, int'(dirOut), 1);
    doCheck("R9 pwm high at start", pwmOut == 2'b11, int'(pwmOut), 3);
    measure(0, hi);
    doCheck("R9 duty ch0", hi == 700, hi, 700);
    measure(1, hi);
    doCheck("R8 duty ch1 same strobe", hi == 5, hi, 5);

    finishRun();
  end
endmodule